// File: doc/BRIEF.md
# Floating-Point Status Field Immediate Writer

This unit holds the 32-bit floating-point status and control register of a processor core. It also executes the one instruction that loads a constant nibble into that register. The core hands the unit each instruction word together with a valid strobe. The unit decodes the word itself. When the word is the field-immediate move, the unit overwrites one of the register's eight 4-bit fields with the 4-bit constant carried in the word, and every other bit keeps its value.

Bit numbering below is LSB-first on the raw word unless stated otherwise. Field k of the register covers bits 31−4k down to 28−4k, so field 0 is the top nibble and field 7 the bottom one. The bottom two bits hold the rounding mode, and the unit exports them directly to the FP datapath.

When the word's record flag is set, the unit also emits a one-cycle condition-register field 1 write carrying the new top nibble. An optional guard input keeps the two summary bits of field 0 from being written, as later revisions of the architecture require.

Top module: `fpscr_fi_unit`

## Requirements
- R1: A word matches when raw bits [31:26] equal 63 and raw bits [10:1] equal 134. `match_q` is high in the cycle after a valid matching word and low in the cycle after any other cycle.
- R2: On a match, the field selected by raw bits [25:23] is loaded with raw bits [15:12] one clock later. Field k occupies register bits [31−4k:28−4k].
- R3: A matching write changes no register bit outside the selected field.
- R4: A valid word that does not match, or any word presented with `instr_valid` low, leaves the register unchanged.
- R5: When raw bit 0 of a matching word is 1, `cr1_we` is high for exactly the following cycle, and `cr1_val` equals register bits [31:28] after the write (FX, FEX, VX, OX from MSB to LSB). When raw bit 0 is 0, `cr1_we` stays low.
- R6: `round_mode` equals register bits [1:0]: 0 is nearest, 1 is toward zero, 2 is toward +infinity, 3 is toward −infinity.
- R7: With `restrict_en` high, a write to field 0 leaves register bits 30 and 29 at their previous values and still loads bits 31 and 28.
- R8: A synchronous active-high `rst` clears the register, `cr1_we`, `cr1_val` and `match_q`.
- R9: Matching words on consecutive cycles are each applied in turn. The second word acts on the result of the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Qualifies `instr_word` this cycle |
| instr_word | input | 32 | Instruction word, raw LSB-first numbering |
| restrict_en | input | 1 | Protects field 0 summary bits (30, 29) |
| status_q | output | 32 | Status and control register |
| round_mode | output | 2 | Rounding mode, register bits [1:0] |
| cr1_we | output | 1 | One-cycle write strobe for CR field 1 |
| cr1_val | output | 4 | Value for CR field 1 |
| match_q | output | 1 | Previous cycle held a valid matching word |

## Verification
The register, the rounding mode, the match flag and the CR1 strobe with its value are all due one clock after the instruction is presented. The strobe is gone again one clock after that, unless another recording word follows. The bench drives each word on a falling edge and samples every result on the next falling edge, half a period after the rising edge that captures it. It then samples once more a full clock later to confirm that the strobe and the match flag have dropped. Back-to-back words are checked at each intermediate falling edge, so each result is checked in the cycle its requirement names.

// File: rtl/fpscr_fi_pkg.sv
package fpscr_fi_pkg;
  // Fixed instruction format (raw word, LSB-first numbering)
  localparam int unsigned INSN_W    = 32;
  localparam logic [5:0]  PRI_OP    = 6'd63;
  localparam logic [9:0]  EXT_OP    = 10'd134;
  localparam int unsigned SEL_LO    = 23;
  localparam int unsigned SEL_BITS  = 3;
  localparam int unsigned IMM_LO    = 12;
  localparam int unsigned IMM_BITS  = 4;

  typedef struct packed {
    logic                hit;
    logic                rec;
    logic [SEL_BITS-1:0] sel;
    logic [IMM_BITS-1:0] imm;
  } fi_op_t;
endpackage

// File: rtl/fpscr_fi_decode.sv
module fpscr_fi_decode
  import fpscr_fi_pkg::*;
(
  input  logic              valid,
  input  logic [INSN_W-1:0] word,
  output fi_op_t            op
);
  logic pri_ok;
  logic ext_ok;

  always_comb begin
    pri_ok = (word[INSN_W-1 -: 6] == PRI_OP);
    ext_ok = (word[10:1] == EXT_OP);
    op.hit = valid && pri_ok && ext_ok;
    op.rec = word[0];
    op.sel = word[SEL_LO +: SEL_BITS];
    op.imm = word[IMM_LO +: IMM_BITS];
  end
endmodule

// File: rtl/fpscr_fi_merge.sv
module fpscr_fi_merge #(
  parameter int unsigned FIELD_W    = 4,
  parameter int unsigned NUM_FIELDS = 8,
  parameter logic [FIELD_W-1:0] F0_GUARD = 4'b0110,
  localparam int unsigned DATA_W = FIELD_W * NUM_FIELDS,
  localparam int unsigned SEL_W  = $clog2(NUM_FIELDS)
) (
  input  logic [DATA_W-1:0]  cur,
  input  logic [SEL_W-1:0]   sel,
  input  logic [FIELD_W-1:0] imm,
  input  logic               guard_en,
  output logic [DATA_W-1:0]  nxt
);
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam int unsigned LO = DATA_W - FIELD_W * (i + 1);
    logic [FIELD_W-1:0] put;
    if (i == 0) begin : g_guarded
      always_comb
        put = guard_en ? ((imm & ~F0_GUARD) | (cur[LO +: FIELD_W] & F0_GUARD)) : imm;
    end else begin : g_plain
      always_comb put = imm;
    end
    assign nxt[LO +: FIELD_W] = (sel == SEL_W'(i)) ? put : cur[LO +: FIELD_W];
  end
endmodule

// File: rtl/fpscr_fi_unit.sv
module fpscr_fi_unit
  import fpscr_fi_pkg::*;
#(
  parameter int unsigned FIELD_W    = 4,
  parameter int unsigned NUM_FIELDS = 8,
  parameter int unsigned RM_W       = 2,
  localparam int unsigned DATA_W = FIELD_W * NUM_FIELDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [INSN_W-1:0] instr_word,
  input  logic              restrict_en,
  output logic [DATA_W-1:0] status_q,
  output logic [RM_W-1:0]   round_mode,
  output logic              cr1_we,
  output logic [FIELD_W-1:0] cr1_val,
  output logic              match_q
);
  fi_op_t            op;
  logic [DATA_W-1:0] nxt;

  fpscr_fi_decode u_dec (
    .valid (instr_valid),
    .word  (instr_word),
    .op    (op)
  );

  fpscr_fi_merge #(
    .FIELD_W    (FIELD_W),
    .NUM_FIELDS (NUM_FIELDS)
  ) u_merge (
    .cur      (status_q),
    .sel      (op.sel),
    .imm      (op.imm),
    .guard_en (restrict_en),
    .nxt      (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      cr1_we   <= 1'b0;
      cr1_val  <= '0;
      match_q  <= 1'b0;
    end else begin
      match_q <= op.hit;
      cr1_we  <= op.hit && op.rec;
      if (op.hit) begin
        status_q <= nxt;
        if (op.rec) cr1_val <= nxt[DATA_W-1 -: FIELD_W];
      end
    end
  end

  assign round_mode = status_q[RM_W-1:0];
endmodule

// File: rtl/fpscr_fi_chk.sv
module fpscr_fi_chk (
  input logic        clk,
  input logic        rst,
  input logic        instr_valid,
  input logic [31:0] instr_word,
  input logic        restrict_en,
  input logic [31:0] status_q,
  input logic        cr1_we,
  input logic [3:0]  cr1_val,
  input logic        match_q
);
  logic [31:0] keep_mask;
  always_comb keep_mask = ~(32'hF000_0000 >> {instr_word[25:23], 2'b00});

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> $stable(status_q)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> (!match_q && !cr1_we)); // R1

  AST_ONLY_FIELD: assert property (@(posedge clk) disable iff (rst)
    instr_valid |=> (((status_q ^ $past(status_q)) & $past(keep_mask)) == 32'h0)); // R3

  AST_CR1_TOP: assert property (@(posedge clk) disable iff (rst)
    cr1_we |-> (match_q && cr1_val == status_q[31:28])); // R5

  AST_SUMMARY_GUARD: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && restrict_en) |=> (status_q[30:29] == $past(status_q[30:29]))); // R7
endmodule

bind fpscr_fi_unit fpscr_fi_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .instr_valid (instr_valid),
  .instr_word  (instr_word),
  .restrict_en (restrict_en),
  .status_q    (status_q),
  .cr1_we      (cr1_we),
  .cr1_val     (cr1_val),
  .match_q     (match_q)
);

// File: tb/tb_fpscr_fi_unit.sv
`timescale 1ns/1ps
module tb_fpscr_fi_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic        restrict_en = 1'b0;
  logic [31:0] status_q;
  logic [1:0]  round_mode;
  logic        cr1_we;
  logic [3:0]  cr1_val;
  logic        match_q;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] model = '0;

  always #2.5 clk = ~clk;

  fpscr_fi_unit dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .restrict_en(restrict_en), .status_q(status_q), .round_mode(round_mode),
    .cr1_we(cr1_we), .cr1_val(cr1_val), .match_q(match_q)
  );

  // vector: {rec, restrict, sel[2:0], imm[3:0]}
  localparam int NV = 10;
  localparam logic [8:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd7, 4'd1},
    {1'b0, 1'b0, 3'd7, 4'd2},
    {1'b0, 1'b0, 3'd7, 4'd3},
    {1'b0, 1'b0, 3'd7, 4'd0},
    {1'b1, 1'b0, 3'd0, 4'hF},
    {1'b0, 1'b0, 3'd3, 4'hA},
    {1'b1, 1'b1, 3'd0, 4'h0},
    {1'b0, 1'b1, 3'd4, 4'h5},
    {1'b1, 1'b0, 3'd0, 4'h9},
    {1'b0, 1'b0, 3'd1, 4'hC}
  };

  function automatic logic [31:0] mk(input logic [5:0] pri, input logic [9:0] xo,
                                     input logic [2:0] sel, input logic [3:0] imm,
                                     input logic rc);
    return {pri, sel, 7'd0, imm, 1'b0, xo, rc};
  endfunction

  function automatic logic [31:0] ref_apply(input logic [31:0] old, input logic [2:0] sel,
                                            input logic [3:0] imm, input logic guard);
    logic [31:0] r;
    r = old;
    r[(28 - 4 * int'(sel)) +: 4] = imm;
    if (guard && sel == 3'd0) r[30:29] = old[30:29];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] w);
    @(negedge clk);
    instr_valid = v;
    instr_word  = w;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic rc, gd;
    logic [2:0] sel;
    logic [3:0] imm;
    repeat (3) @(negedge clk);
    // R8 reset state
    drive(1'b0, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 status", status_q, 32'h0);
    chk("R8 match", {31'd0, match_q}, 32'd0);
    chk("R8 cr1_we", {31'd0, cr1_we}, 32'd0);
    chk("R6 rm reset", {30'd0, round_mode}, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      {rc, gd, sel, imm} = VEC[i];
      restrict_en = gd;
      drive(1'b1, mk(6'd63, 10'd134, sel, imm, rc));
      drive(1'b0, '0);
      model = ref_apply(model, sel, imm, gd);
      chk("R2/R3 status", status_q, model);
      chk("R1 match", {31'd0, match_q}, 32'd1);
      chk("R5 cr1_we", {31'd0, cr1_we}, {31'd0, rc});
      if (rc) chk("R5 cr1_val", {28'd0, cr1_val}, {28'd0, model[31:28]});
      chk("R6 round_mode", {30'd0, round_mode}, {30'd0, model[1:0]});
      if (gd && sel == 3'd0) chk("R7 summary kept", {30'd0, status_q[30:29]}, {30'd0, model[30:29]});
      @(negedge clk);
      chk("R5 strobe one cycle", {31'd0, cr1_we}, 32'd0);
      chk("R1 match drops", {31'd0, match_q}, 32'd0);
    end
    restrict_en = 1'b0;

    // R4 wrong primary opcode
    drive(1'b1, mk(6'd62, 10'd134, 3'd7, 4'd3, 1'b1));
    drive(1'b0, '0);
    chk("R4 bad primary status", status_q, model);
    chk("R1 bad primary match", {31'd0, match_q}, 32'd0);
    chk("R5 bad primary cr1_we", {31'd0, cr1_we}, 32'd0);
    // R4 wrong extended opcode
    drive(1'b1, mk(6'd63, 10'd135, 3'd2, 4'd7, 1'b0));
    drive(1'b0, '0);
    chk("R4 bad ext status", status_q, model);
    chk("R1 bad ext match", {31'd0, match_q}, 32'd0);
    // R4 matching word with valid low
    drive(1'b0, mk(6'd63, 10'd134, 3'd5, 4'd6, 1'b1));
    drive(1'b0, '0);
    chk("R4 invalid status", status_q, model);
    chk("R5 invalid cr1_we", {31'd0, cr1_we}, 32'd0);

    // R9 back-to-back, second acts on first's result (field 0 twice)
    drive(1'b1, mk(6'd63, 10'd134, 3'd0, 4'h3, 1'b1));
    drive(1'b1, mk(6'd63, 10'd134, 3'd0, 4'hC, 1'b1));
    model = ref_apply(model, 3'd0, 4'h3, 1'b0);
    chk("R9 first status", status_q, model);
    chk("R9 first cr1_val", {28'd0, cr1_val}, 32'h3);
    drive(1'b1, mk(6'd63, 10'd134, 3'd6, 4'hB, 1'b0));
    model = ref_apply(model, 3'd0, 4'hC, 1'b0);
    chk("R9 second status", status_q, model);
    chk("R9 second cr1_val", {28'd0, cr1_val}, 32'hC);
    chk("R5 strobe held by second rec", {31'd0, cr1_we}, 32'd1);
    drive(1'b0, '0);
    model = ref_apply(model, 3'd6, 4'hB, 1'b0);
    chk("R9 third status", status_q, model);
    chk("R5 no strobe for plain form", {31'd0, cr1_we}, 32'd0);
    chk("R1 third match", {31'd0, match_q}, 32'd1);

    // R8 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R8 status after reset", status_q, 32'h0);
    chk("R8 match after reset", {31'd0, match_q}, 32'd0);
    chk("R8 cr1_val after reset", {28'd0, cr1_val}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule